// File: doc/BRIEF.md
# Video Clock Enable Divider Chain

This block turns one of three reference enable streams into a video clock enable. The streams stand for two PLL outputs and an external clock. All logic runs in a single system clock domain. Each reference is a qualifying enable that is high for one system clock per reference edge. It is not treated as a clock in its own right, so no glitch-free clock switching is involved.

Two select bits choose the source. The chosen stream then passes through a prescaler that divides by 2, 2.5 or 3, or holds its output off. The fractional ratio alternates periods of two and three input enables. The prescaler output drives a programmable divide-by-N stage. The result is a registered single-cycle pulse on `vclk_en`, which runs at the source rate divided by the prescale ratio and then by N.

Any change to the configuration clears every divider counter, so the first pulse after the change has a full, clean period.

Top module: `vcd_chain`

## Requirements
- R1: When `sel_ext` is 1 the source is `ref_ext_en`. Otherwise `sel_ab` picks `ref_a_en` (0) or `ref_b_en` (1). Enables on the two unselected inputs have no effect on `vclk_en`.
- R2: `pre_code` 2'b00 makes the prescaler emit one enable for every 2 source enables.
- R3: `pre_code` 2'b01 divides by 2.5. The first prescaler enable follows 2 source enables, the next follows 3 more, and the pattern alternates. After k source enables from a clean start, floor((2k+1)/5) prescaler enables have occurred.
- R4: `pre_code` 2'b10 makes the prescaler emit one enable for every 3 source enables.
- R5: `pre_code` 2'b11 produces no pulses on `vclk_en` and holds the counters at zero, so a later ratio starts from a clean period.
- R6: The divide-by-N stage emits one pulse for every `n_div` prescaler enables, when `n_div` is 2 or more.
- R7: An `n_div` of 0 or 1 behaves exactly like 2.
- R8: In the cycle where `sel_ext`, `sel_ab`, `pre_code` or `n_div` differ from their values in the previous cycle, all counters clear. A source enable in that cycle is discarded, even if it would have completed a period.
- R9: `vclk_en` is high for exactly one cycle. It rises in the cycle after the source enable that completes the period.
- R10: After reset `vclk_en` is 0 and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_a_en | input | 1 | First PLL reference enable |
| ref_b_en | input | 1 | Second PLL reference enable |
| ref_ext_en | input | 1 | External clock reference enable |
| sel_ab | input | 1 | 0 selects `ref_a_en`, 1 selects `ref_b_en` |
| sel_ext | input | 1 | 1 selects `ref_ext_en` over the PLL choice |
| pre_code | input | 2 | Prescaler code: 00 div 2, 01 div 2.5, 10 div 3, 11 off |
| n_div | input | NW (8) | Divide-by-N value; values below 2 act as 2 |
| vclk_en | output | 1 | Single-cycle video clock enable |

## Verification
A configuration change can fall in the same cycle as a source enable that would otherwise complete a divide-by-N period. The bench provokes this by first feeding three enables at divide-by-2 with N of 2. It then raises the fourth enable in the same cycle that it switches the prescaler to divide-by-3. The clear must win: no pulse may appear in the following cycle, and the next pulse must arrive only after a full six fresh enables, not earlier.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

  typedef enum logic [1:0] {
    PRE_DIV2  = 2'b00,
    PRE_DIV25 = 2'b01,
    PRE_DIV3  = 2'b10,
    PRE_OFF   = 2'b11
  } pre_code_e;

  localparam int unsigned PRE_CNT_W = 2;

  // Index of the input enable (counting from 0) that closes a prescaler period.
  function automatic logic [PRE_CNT_W-1:0] pre_last(input pre_code_e code, input logic long_ph);
    case (code)
      PRE_DIV2:  pre_last = 2'd1;
      PRE_DIV25: pre_last = long_ph ? 2'd2 : 2'd1;
      PRE_DIV3:  pre_last = 2'd2;
      default:   pre_last = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/vcd_src_sel.sv
module vcd_src_sel (
  input  logic ref_a_en,
  input  logic ref_b_en,
  input  logic ref_ext_en,
  input  logic sel_ab,
  input  logic sel_ext,
  output logic src_en
);
  logic pll_en;

  always_comb begin
    pll_en = sel_ab ? ref_b_en : ref_a_en;
    src_en = sel_ext ? ref_ext_en : pll_en;
  end
endmodule

// File: rtl/vcd_prescale.sv
module vcd_prescale
  import vcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      in_en,
  input  pre_code_e code,
  output logic      out_en
);
  logic [PRE_CNT_W-1:0] cnt;
  logic                 long_ph;
  logic                 off;
  logic [PRE_CNT_W-1:0] last;
  logic                 hit;

  always_comb begin
    off    = (code == PRE_OFF);
    last   = pre_last(code, long_ph);
    hit    = in_en && !off && !clr && (cnt == last);
    out_en = hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr || off) begin
      cnt     <= '0;
      long_ph <= 1'b0;
    end else if (in_en) begin
      if (hit) begin
        cnt     <= '0;
        long_ph <= (code == PRE_DIV25) ? ~long_ph : 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);

  p_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (cnt == '0 && !long_ph));

  p_alt_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && code == PRE_DIV25) |=> (long_ph != $past(long_ph)));

  p_no_out_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> !out_en);
endmodule

// File: rtl/vcd_ndiv.sv
module vcd_ndiv #(
  parameter int unsigned NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_en,
  input  logic [NW-1:0] n_cfg,
  output logic          out_en
);
  localparam logic [NW-1:0] N_FLOOR = NW'(2);

  // Last count index of a period; ratios below the floor use the floor.
  function automatic logic [NW-1:0] n_last(input logic [NW-1:0] n);
    n_last = (n < N_FLOOR) ? (N_FLOOR - 1'b1) : (n - 1'b1);
  endfunction

  logic [NW-1:0] cnt;
  logic [NW-1:0] last;
  logic          hit;

  always_comb begin
    last   = n_last(n_cfg);
    hit    = in_en && !clr && (cnt == last);
    out_en = hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (in_en) begin
      cnt <= hit ? '0 : cnt + 1'b1;
    end
  end

  p_ncnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
    cnt <= last);

  p_nmin_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> (cnt == '0));
endmodule

// File: rtl/vcd_chain.sv
module vcd_chain
  import vcd_pkg::*;
#(
  parameter int unsigned NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_a_en,
  input  logic          ref_b_en,
  input  logic          ref_ext_en,
  input  logic          sel_ab,
  input  logic          sel_ext,
  input  logic [1:0]    pre_code,
  input  logic [NW-1:0] n_div,
  output logic          vclk_en
);
  localparam int unsigned CFG_W = NW + 4;

  logic [CFG_W-1:0] cfg_cur;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             src_en;
  logic             pre_en;
  logic             n_hit;
  pre_code_e        code;

  always_comb begin
    cfg_cur = {sel_ext, sel_ab, pre_code, n_div};
    cfg_chg = (cfg_cur != cfg_q);
    code    = pre_code_e'(pre_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      vclk_en <= 1'b0;
    end else begin
      cfg_q   <= cfg_cur;
      vclk_en <= n_hit;
    end
  end

  vcd_src_sel u_src (
    .ref_a_en  (ref_a_en),
    .ref_b_en  (ref_b_en),
    .ref_ext_en(ref_ext_en),
    .sel_ab    (sel_ab),
    .sel_ext   (sel_ext),
    .src_en    (src_en)
  );

  vcd_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_chg),
    .in_en (src_en),
    .code  (code),
    .out_en(pre_en)
  );

  vcd_ndiv #(.NW(NW)) u_ndiv (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_chg),
    .in_en (pre_en),
    .n_cfg (n_div),
    .out_en(n_hit)
  );

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vclk_en |=> !vclk_en);

  p_chg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !vclk_en);

  p_src_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vclk_en) |-> $past(src_en));

  p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code == PRE_OFF) |=> !vclk_en);
endmodule

// File: tb/vcd_chain_tb.sv
module vcd_chain_tb_top;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_a_en = 1'b0, ref_b_en = 1'b0, ref_ext_en = 1'b0;
  logic          sel_ab = 1'b0, sel_ext = 1'b0;
  logic [1:0]    pre_code = 2'b00;
  logic [NW-1:0] n_div = 8'd2;
  logic          vclk_en;

  int checks = 0;
  int fails  = 0;
  int seen   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vcd_chain #(.NW(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_a_en(ref_a_en), .ref_b_en(ref_b_en),
    .ref_ext_en(ref_ext_en), .sel_ab(sel_ab), .sel_ext(sel_ext),
    .pre_code(pre_code), .n_div(n_div), .vclk_en(vclk_en)
  );

  always @(negedge clk) if (rst_n && vclk_en) seen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Configure from a clean state: pass through the off code first.
  task automatic set_cfg(input bit ext, input bit ab, input logic [1:0] code, input int n);
    @(negedge clk);
    pre_code = 2'b11;
    @(negedge clk);
    sel_ext = ext; sel_ab = ab; pre_code = code; n_div = NW'(n);
    idle(2);
    #1 seen = 0;
  endtask

  // which: 0 = ref_a, 1 = ref_b, 2 = ref_ext
  task automatic feed(input int which, input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      ref_a_en = (which == 0); ref_b_en = (which == 1); ref_ext_en = (which == 2);
    end
    @(negedge clk);
    ref_a_en = 0; ref_b_en = 0; ref_ext_en = 0;
    idle(2);
    #1;
  endtask

  task automatic t_reset;
    #1 check(vclk_en == 1'b0, "R10 reset output", int'(vclk_en), 0);
  endtask

  task automatic t_div2;
    set_cfg(0, 0, 2'b00, 3);
    feed(0, 12);
    check(seen == 2, "R2/R6 div2 N3 12 enables", seen, 2);
    feed(0, 5);
    check(seen == 2, "R6 partial period", seen, 2);
    feed(0, 1);
    check(seen == 3, "R6 completes period", seen, 3);
  endtask

  task automatic t_div25;
    set_cfg(0, 0, 2'b01, 2);
    feed(0, 5);
    check(seen == ((2*5+1)/5)/2, "R3 after 5", seen, ((2*5+1)/5)/2);
    feed(0, 4);
    check(seen == ((2*9+1)/5)/2, "R3 after 9", seen, ((2*9+1)/5)/2);
    feed(0, 1);
    check(seen == ((2*10+1)/5)/2, "R3 after 10", seen, ((2*10+1)/5)/2);
    feed(0, 10);
    check(seen == ((2*20+1)/5)/2, "R3 after 20", seen, ((2*20+1)/5)/2);
  endtask

  task automatic t_div3;
    set_cfg(0, 0, 2'b10, 2);
    feed(0, 11);
    check(seen == 1, "R4 div3 after 11", seen, 1);
    feed(0, 1);
    check(seen == 2, "R4 div3 after 12", seen, 2);
  endtask

  task automatic t_off;
    set_cfg(0, 0, 2'b11, 2);
    feed(0, 20);
    check(seen == 0, "R5 off no pulses", seen, 0);
    @(negedge clk); pre_code = 2'b00; idle(2); #1 seen = 0;
    feed(0, 3);
    check(seen == 0, "R5 clean after off (3)", seen, 0);
    feed(0, 1);
    check(seen == 1, "R5 clean after off (4)", seen, 1);
  endtask

  task automatic t_src;
    set_cfg(0, 1, 2'b00, 2);
    feed(0, 20);
    feed(2, 20);
    check(seen == 0, "R1 unselected ignored", seen, 0);
    feed(1, 4);
    check(seen == 1, "R1 ref_b selected", seen, 1);
    set_cfg(1, 1, 2'b00, 2);
    feed(1, 10);
    feed(0, 10);
    check(seen == 0, "R1 pll ignored under ext", seen, 0);
    feed(2, 8);
    check(seen == 2, "R1 ext selected", seen, 2);
  endtask

  task automatic t_nmin;
    set_cfg(0, 0, 2'b00, 1);
    feed(0, 8);
    check(seen == 2, "R7 N=1 acts as 2", seen, 2);
    set_cfg(0, 0, 2'b00, 0);
    feed(0, 8);
    check(seen == 2, "R7 N=0 acts as 2", seen, 2);
  endtask

  task automatic t_latency;
    set_cfg(0, 0, 2'b00, 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ref_a_en = 1;
    end
    @(negedge clk); ref_a_en = 0;
    #1 check(vclk_en == 1'b0, "R9 no early pulse", int'(vclk_en), 0);
    @(negedge clk); ref_a_en = 1;
    @(negedge clk); ref_a_en = 0;
    #1 check(vclk_en == 1'b1, "R9 pulse next cycle", int'(vclk_en), 1);
    @(negedge clk);
    #1 check(vclk_en == 1'b0, "R9 single cycle", int'(vclk_en), 0);
  endtask

  task automatic t_collide;
    set_cfg(0, 0, 2'b00, 2);
    feed(0, 3);
    @(negedge clk); ref_a_en = 1; pre_code = 2'b10;
    @(negedge clk); ref_a_en = 0;
    #1 check(vclk_en == 1'b0, "R8 change beats completing enable", int'(vclk_en), 0);
    idle(2); #1 seen = 0;
    feed(0, 5);
    check(seen == 0, "R8 counters cleared (5)", seen, 0);
    feed(0, 1);
    check(seen == 1, "R8 full fresh period (6)", seen, 1);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    idle(3);
    t_reset;
    @(negedge clk); rst_n = 1;
    t_div2;
    t_div25;
    t_div3;
    t_off;
    t_src;
    t_nmin;
    t_latency;
    t_collide;
    done = 1;
    report;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report;
    end
  end
endmodule